// File: doc/BRIEF.md
# Flash Controller Status Flag Tracker

This block holds the 16-bit status word of a flash memory controller and keeps its flags current as events arrive from the command path, the system bus and the sleep controller. Command strobes cover page buffer loads, page writes, page buffer clears, entering and leaving power reduction, and the start and completion of program or erase operations. Sleep entry and exit events change the power-reduction flag only when the sleep power-reduction enable is on. Any bus access to the memory also takes it out of power reduction.

A 2-bit debug access level fuse input is sampled every clock and shown in the status word. The field always shows the pending fuse value. A separate output carries the level in force, which is frozen while the access-level unlock bit is high. Every status bit is read-only, so no write path exists. The secure and non-secure read paths both take the same status word.

Top module: `nvmStatusTracker`

## Requirements
- R1: Bits 15:5 of `statusWord` always read 0.
- R2: While `rstN` is low, bits 2:0 (ready at bit 2, load at bit 1, power reduction at bit 0) read 0. Bits 4:3 show the fuse input sampled at the last clock edge.
- R3: Ready (bit 2) becomes 1 at the first clock edge after reset is released. It drops to 0 at the edge that samples `progStart` and returns to 1 at the edge that samples `progDone`. If both strobes are sampled at the same edge, ready goes to 0.
- R4: Load (bit 1) becomes 1 at the edge that samples `cmdLoad`. It then stays 1 until an edge samples `cmdPageWrite` or `cmdBufClear`, and goes to 0 at that edge.
- R5: If `cmdLoad` is sampled at the same edge as `cmdPageWrite` or `cmdBufClear`, load ends at 0.
- R6: Power reduction (bit 0) becomes 1 at the edge that samples `cmdSetPrm`, or at the edge that samples `sleepEnter` while `sleepPrmEn` is 1. A `sleepEnter` with `sleepPrmEn` at 0 leaves the bit unchanged.
- R7: Power reduction goes to 0 at the edge that samples any of these: `busAccess`, `cmdClrPrm`, or `sleepExit` with `sleepPrmEn` at 1. A `sleepExit` with `sleepPrmEn` at 0 leaves the bit unchanged.
- R8: If a set event and a clear event for power reduction are sampled at the same edge, the bit ends at 0.
- R9: Bits 4:3 equal `fuseLevel` as sampled at the previous edge, whatever the value of `levelUnlock`. The encoding is: 0 gives very limited access, 1 gives non-secure-only access, 2 gives full access, and 3 is reserved.
- R10: `activeLevel` resets to 0. It loads `fuseLevel` at each edge where `levelUnlock` is 0, and holds its value at each edge where `levelUnlock` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdLoad | input | 1 | Page buffer load strobe |
| cmdPageWrite | input | 1 | Page write command strobe |
| cmdBufClear | input | 1 | Page buffer clear command strobe |
| cmdSetPrm | input | 1 | Enter power reduction command strobe |
| cmdClrPrm | input | 1 | Leave power reduction command strobe |
| progStart | input | 1 | Program or erase has started |
| progDone | input | 1 | Program or erase has completed |
| sleepEnter | input | 1 | Sleep entry event |
| sleepExit | input | 1 | Sleep exit event |
| sleepPrmEn | input | 1 | Sleep changes power reduction when 1 |
| busAccess | input | 1 | Bus access to the memory |
| fuseLevel | input | 2 | Debug access level fuse value |
| levelUnlock | input | 1 | Access-level unlock; freezes activeLevel when 1 |
| statusWord | output | 16 | Read-only status word |
| activeLevel | output | 2 | Debug access level currently in force |

## Verification
Each flag is a single register fed by combinational event decode. A strobe driven before an edge is therefore due in `statusWord` right after that edge. The fuse field and `activeLevel` follow the same one-edge rule, and ready takes one edge to rise after reset is released. The bench changes inputs on the falling edge and reads results on the next falling edge, half a period after the edge that loads them. It also repeats the read a few edges later to confirm that held values stay put. For the same-cycle conflicts, both events go in a single cycle and the bench checks that the clearing side wins.

// File: rtl/nvmStatusPkg.sv
package nvmStatusPkg;
  localparam int STATUS_W   = 16;
  localparam int LEVEL_W    = 2;
  localparam int LEVEL_LSB  = 3;
  localparam int READY_BIT  = 2;
  localparam int LOAD_BIT   = 1;
  localparam int PRM_BIT    = 0;
  localparam int USED_W     = LEVEL_LSB + LEVEL_W;

  typedef struct packed {
    logic setLoad;
    logic clrLoad;
    logic setPrm;
    logic clrPrm;
    logic busyGo;
    logic busyEnd;
  } flagStrobes_t;
endpackage

// File: rtl/nvmStatusCtrl.sv
module nvmStatusCtrl
  import nvmStatusPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdLoad,
  input  logic         cmdPageWrite,
  input  logic         cmdBufClear,
  input  logic         cmdSetPrm,
  input  logic         cmdClrPrm,
  input  logic         progStart,
  input  logic         progDone,
  input  logic         sleepEnter,
  input  logic         sleepExit,
  input  logic         sleepPrmEn,
  input  logic         busAccess,
  output flagStrobes_t strobes
);
  logic initDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initDone <= 1'b0;
    else       initDone <= 1'b1;
  end

  always_comb begin
    strobes         = '0;
    strobes.setLoad = cmdLoad;
    strobes.clrLoad = cmdPageWrite | cmdBufClear;
    strobes.setPrm  = cmdSetPrm | (sleepEnter & sleepPrmEn);
    strobes.clrPrm  = busAccess | cmdClrPrm | (sleepExit & sleepPrmEn);
    strobes.busyGo  = progStart;
    strobes.busyEnd = progDone | ~initDone;
  end
endmodule

// File: rtl/nvmStatusDatapath.sv
module nvmStatusDatapath
  import nvmStatusPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  flagStrobes_t       strobes,
  input  logic [LEVEL_W-1:0] fuseLevel,
  input  logic               levelUnlock,
  output logic               readyQ,
  output logic               loadQ,
  output logic               prmQ,
  output logic [LEVEL_W-1:0] fuseQ,
  output logic [LEVEL_W-1:0] activeQ
);
  // Busy/ready: a new operation start takes precedence over completion.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                readyQ <= 1'b0;
    else if (strobes.busyGo)  readyQ <= 1'b0;
    else if (strobes.busyEnd) readyQ <= 1'b1;
  end

  // Page buffer loaded flag: clear takes precedence.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                loadQ <= 1'b0;
    else if (strobes.clrLoad) loadQ <= 1'b0;
    else if (strobes.setLoad) loadQ <= 1'b1;
  end

  // Power reduction flag: clear takes precedence.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               prmQ <= 1'b0;
    else if (strobes.clrPrm) prmQ <= 1'b0;
    else if (strobes.setPrm) prmQ <= 1'b1;
  end

  // Pending fuse value: sampled every edge, reset-free so it is valid in reset.
  always_ff @(posedge clk) begin
    fuseQ <= fuseLevel;
  end

  // Level in force: frozen while unlocked.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             activeQ <= '0;
    else if (!levelUnlock) activeQ <= fuseLevel;
  end

  a_r3_start_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    strobes.busyGo |=> !readyQ);
  a_r3_done_raises_ready: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busyEnd && !strobes.busyGo) |=> readyQ);
  a_r4_load_holds: assert property (@(posedge clk) disable iff (!rstN)
    (loadQ && !strobes.clrLoad) |=> loadQ);
  a_r5_load_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrLoad |=> !loadQ);
  a_r8_prm_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrPrm |=> !prmQ);
  a_r6_prm_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setPrm && !strobes.clrPrm) |=> prmQ);
  a_r10_level_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (levelUnlock && $past(rstN)) |=> $stable(activeQ));
endmodule

// File: rtl/nvmStatusTracker.sv
module nvmStatusTracker
  import nvmStatusPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdLoad,
  input  logic               cmdPageWrite,
  input  logic               cmdBufClear,
  input  logic               cmdSetPrm,
  input  logic               cmdClrPrm,
  input  logic               progStart,
  input  logic               progDone,
  input  logic               sleepEnter,
  input  logic               sleepExit,
  input  logic               sleepPrmEn,
  input  logic               busAccess,
  input  logic [LEVEL_W-1:0] fuseLevel,
  input  logic               levelUnlock,
  output logic [STATUS_W-1:0] statusWord,
  output logic [LEVEL_W-1:0]  activeLevel
);
  flagStrobes_t       strobes;
  logic               readyQ;
  logic               loadQ;
  logic               prmQ;
  logic [LEVEL_W-1:0] fuseQ;

  nvmStatusCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdLoad      (cmdLoad),
    .cmdPageWrite (cmdPageWrite),
    .cmdBufClear  (cmdBufClear),
    .cmdSetPrm    (cmdSetPrm),
    .cmdClrPrm    (cmdClrPrm),
    .progStart    (progStart),
    .progDone     (progDone),
    .sleepEnter   (sleepEnter),
    .sleepExit    (sleepExit),
    .sleepPrmEn   (sleepPrmEn),
    .busAccess    (busAccess),
    .strobes      (strobes)
  );

  nvmStatusDatapath uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .fuseLevel   (fuseLevel),
    .levelUnlock (levelUnlock),
    .readyQ      (readyQ),
    .loadQ       (loadQ),
    .prmQ        (prmQ),
    .fuseQ       (fuseQ),
    .activeQ     (activeLevel)
  );

  always_comb begin
    statusWord                                = '0;
    statusWord[LEVEL_LSB +: LEVEL_W]          = fuseQ;
    statusWord[READY_BIT]                     = readyQ;
    statusWord[LOAD_BIT]                      = loadQ;
    statusWord[PRM_BIT]                       = prmQ;
  end

  a_r9_field_tracks_fuse: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> statusWord[LEVEL_LSB +: LEVEL_W] == $past(fuseLevel));
  a_r2_flags_low_in_reset: assert property (@(posedge clk)
    !rstN |-> statusWord[READY_BIT:PRM_BIT] == '0);
endmodule

// File: tb/tb_nvmStatusTracker.sv
`timescale 1ns/1ps
module tb_nvmStatusTracker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdLoad = 0, cmdPageWrite = 0, cmdBufClear = 0, cmdSetPrm = 0, cmdClrPrm = 0;
  logic progStart = 0, progDone = 0, sleepEnter = 0, sleepExit = 0, sleepPrmEn = 0;
  logic busAccess = 0, levelUnlock = 0;
  logic [1:0] fuseLevel = 2'd2;
  logic [15:0] statusWord;
  logic [1:0]  activeLevel;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nvmStatusTracker dut (
    .clk(clk), .rstN(rstN), .cmdLoad(cmdLoad), .cmdPageWrite(cmdPageWrite),
    .cmdBufClear(cmdBufClear), .cmdSetPrm(cmdSetPrm), .cmdClrPrm(cmdClrPrm),
    .progStart(progStart), .progDone(progDone), .sleepEnter(sleepEnter),
    .sleepExit(sleepExit), .sleepPrmEn(sleepPrmEn), .busAccess(busAccess),
    .fuseLevel(fuseLevel), .levelUnlock(levelUnlock),
    .statusWord(statusWord), .activeLevel(activeLevel));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearStrobes;
    cmdLoad = 0; cmdPageWrite = 0; cmdBufClear = 0; cmdSetPrm = 0; cmdClrPrm = 0;
    progStart = 0; progDone = 0; sleepEnter = 0; sleepExit = 0; busAccess = 0;
  endtask

  task automatic testReset;
    tick(3);
    check("R2 flags in reset", {13'd0, statusWord[2:0]}, 16'h0000);
    check("R2 fuse in reset", {14'd0, statusWord[4:3]}, 16'd2);
    check("R1 reserved in reset", {5'd0, statusWord[15:5]}, 16'h0000);
    rstN = 1;
    tick();
    check("R3 ready after reset", {15'd0, statusWord[2]}, 16'd1);
    check("R10 active after reset", {14'd0, activeLevel}, 16'd2);
  endtask

  task automatic testReady;
    progStart = 1; tick(); clearStrobes();
    check("R3 busy after start", {15'd0, statusWord[2]}, 16'd0);
    tick(3);
    check("R3 busy held", {15'd0, statusWord[2]}, 16'd0);
    progDone = 1; tick(); clearStrobes();
    check("R3 ready after done", {15'd0, statusWord[2]}, 16'd1);
    progStart = 1; progDone = 1; tick(); clearStrobes();
    check("R3 start wins over done", {15'd0, statusWord[2]}, 16'd0);
    progDone = 1; tick(); clearStrobes();
  endtask

  task automatic testLoad;
    cmdLoad = 1; tick(); clearStrobes();
    check("R4 load set", {15'd0, statusWord[1]}, 16'd1);
    tick(4);
    check("R4 load held", {15'd0, statusWord[1]}, 16'd1);
    cmdPageWrite = 1; tick(); clearStrobes();
    check("R4 page write clears", {15'd0, statusWord[1]}, 16'd0);
    cmdLoad = 1; tick(); clearStrobes();
    cmdBufClear = 1; tick(); clearStrobes();
    check("R4 buffer clear clears", {15'd0, statusWord[1]}, 16'd0);
    cmdLoad = 1; tick();
    cmdBufClear = 1; tick(); clearStrobes();
    check("R5 clear wins (buffer clear)", {15'd0, statusWord[1]}, 16'd0);
    cmdLoad = 1; tick();
    cmdPageWrite = 1; tick(); clearStrobes();
    check("R5 clear wins (page write)", {15'd0, statusWord[1]}, 16'd0);
  endtask

  task automatic testPrm;
    cmdSetPrm = 1; tick(); clearStrobes();
    check("R6 set by command", {15'd0, statusWord[0]}, 16'd1);
    sleepPrmEn = 0; sleepExit = 1; tick(); clearStrobes();
    check("R7 sleep exit ignored when disabled", {15'd0, statusWord[0]}, 16'd1);
    busAccess = 1; tick(); clearStrobes();
    check("R7 cleared by bus access", {15'd0, statusWord[0]}, 16'd0);
    sleepEnter = 1; tick(); clearStrobes();
    check("R6 sleep entry ignored when disabled", {15'd0, statusWord[0]}, 16'd0);
    sleepPrmEn = 1; sleepEnter = 1; tick(); clearStrobes();
    check("R6 set by sleep entry", {15'd0, statusWord[0]}, 16'd1);
    sleepExit = 1; tick(); clearStrobes();
    check("R7 cleared by sleep exit", {15'd0, statusWord[0]}, 16'd0);
    cmdSetPrm = 1; tick(); clearStrobes();
    cmdClrPrm = 1; tick(); clearStrobes();
    check("R7 cleared by command", {15'd0, statusWord[0]}, 16'd0);
    cmdSetPrm = 1; busAccess = 1; tick(); clearStrobes();
    check("R8 clear wins over command set", {15'd0, statusWord[0]}, 16'd0);
    sleepEnter = 1; cmdClrPrm = 1; tick(); clearStrobes();
    check("R8 clear wins over sleep set", {15'd0, statusWord[0]}, 16'd0);
    sleepPrmEn = 0;
  endtask

  task automatic testLevel;
    levelUnlock = 0; fuseLevel = 2'd1; tick();
    check("R9 field follows fuse", {14'd0, statusWord[4:3]}, 16'd1);
    check("R10 active follows fuse", {14'd0, activeLevel}, 16'd1);
    levelUnlock = 1; fuseLevel = 2'd0; tick();
    check("R9 field shows pending level", {14'd0, statusWord[4:3]}, 16'd0);
    check("R10 active frozen while unlocked", {14'd0, activeLevel}, 16'd1);
    fuseLevel = 2'd3; tick(2);
    check("R9 field reserved code", {14'd0, statusWord[4:3]}, 16'd3);
    check("R10 active still frozen", {14'd0, activeLevel}, 16'd1);
    levelUnlock = 0; fuseLevel = 2'd2; tick();
    check("R10 active resumes", {14'd0, activeLevel}, 16'd2);
    check("R1 reserved bits zero", {5'd0, statusWord[15:5]}, 16'h0000);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testReady();
    testLoad();
    testPrm();
    testLevel();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule